// File: doc/BRIEF.md
# Video Control Register Bank with Field-Synchronous Updates

This block is a two-wire serial (I2C) slave that holds the control bytes of a video processing chip. A controller addresses the device, sends a register index, and then streams data bytes into consecutive registers. The block presents every register at once on a parallel output bus, so the analog and picture-processing logic around it can read its settings directly. A read from the device returns one status byte built from live flag inputs.

Picture settings that would show a visible step if they changed halfway through a field are staged. A write to one of these settings lands in a shadow byte first. The shadow byte is copied to the visible register on the next vertical sync strobe. Index 0x06 is a mixed register: only its two source-select bits are staged, and its other bits take effect at once.

The serial lines are brought into the system clock domain through a two-flop stage. A state machine then decodes the lines with nine named states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the device address.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_SUB`: shifts in the register index.
- `ST_SUB_ACK`: acknowledges the index.
- `ST_DATA`: shifts in a data byte.
- `ST_DATA_ACK`: acknowledges the data byte.
- `ST_TX`: sends the status byte.
- `ST_TX_ACK`: samples the controller's acknowledge.

The transitions are:
- START from any state goes to `ST_ADDR`, and STOP from any state goes to `ST_IDLE`.
- After eight address bits, a matching address goes to `ST_ADDR_ACK`; any other address goes back to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_TX` for a read or to `ST_SUB` for a write.
- `ST_SUB` goes to `ST_SUB_ACK`, which goes to `ST_DATA`.
- `ST_DATA` goes to `ST_DATA_ACK`, which goes back to `ST_DATA`.
- After eight bits, `ST_TX` goes to `ST_TX_ACK`. From there, an acknowledge goes back to `ST_TX` and a not-acknowledge goes to `ST_IDLE`.

Top module: `vid_ctrl_regbank`

## Requirements
- R1: After reset, the registers hold these values: 0x04=0x20, 0x05=0x40, 0x06=0x80, 0x07=0x40, 0x08=0x40, 0x0A=0x80, 0x0D/0x0E/0x0F=0x80, 0x10=0x24, 0x16=0x90, 0x17=0x40. Every other index holds 0x00. Register n appears on `regs_out[8n+7:8n]`.
- R2: The device answers only to the 7-bit address 1011101 (address byte 0xBA to write, 0xBB to read) by pulling SDA low in the ninth clock. No other address is acknowledged. The block never changes its SDA drive while SCL is high.
- R3: A write to an unstaged register appears on `regs_out` when its data byte is acknowledged, without any vertical sync.
- R4: The index advances by one after each data byte of a write, so N data bytes fill N consecutive registers.
- R5: Registers 0x04, 0x05, 0x07, 0x0A and 0x17 keep their visible value after a write. They take the written value only at the clock edge where `vsync_stb` is high.
- R6: If several writes reach a staged register before one vertical sync strobe, only the last value becomes visible.
- R7: In register 0x06, bits 4 and 3 are staged as in R5, and bits 7:5 and 2:0 update at once as in R3.
- R8: Writes to indices 0x00, 0x01, 0x0B, 0x0C, 0x11, 0x1B, 0x1C, and to any index above 0x1C, are acknowledged and discarded. Those registers stay 0x00.
- R9: A read returns the status byte as follows:
  - bit7 = `stat_in[5]` (colour killer off)
  - bit5 = `stat_in[4]` (vertical sync missing)
  - bit4 = `stat_in[3]` (no station)
  - bit3 = `stat_in[2]` (tuning flag 0)
  - bit2 = `stat_in[1]` (tuning flag 1)
  - bit1 = `stat_in[0]` (line lock lost)
  - bits 6 and 0 are 0.
  
  The status byte is sampled again for each byte that the controller acknowledges.
- R10: A STOP in the middle of a data byte abandons the byte without writing it. A later START always restarts address decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| vsync_stb | input | 1 | One-cycle vertical sync strobe that commits staged bytes |
| stat_in | input | 6 | Live status flags placed into the read byte |
| sda_pull | output | 1 | High drives the data line low (open-drain enable) |
| regs_out | output | 232 | All 29 visible registers, register n on bits 8n+7:8n |

## Verification
A wrong shift count or a wrong state shows up first on `sda_pull`. The acknowledge arrives one SCL period too early or too late, or a read bit is misplaced, and both are visible within the same byte. A wrong index pointer or a wrong staging mask shows up on `regs_out` a few cycles after the data byte is acknowledged, or on the cycle after the next `vsync_stb`. A reference model therefore compares every register on every clock outside the short commit windows. A shadow byte that is lost or stale stays hidden until a strobe arrives, so each staged write is followed by a strobe and a comparison.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK
    } slv_state_e;

    // Power-up contents of each register index.
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            4:              v = 8'h20;
            5, 7, 8, 23:    v = 8'h40;
            6, 10:          v = 8'h80;
            13, 14, 15:     v = 8'h80;
            16:             v = 8'h24;
            22:             v = 8'h90;
            default:        v = 8'h00;
        endcase
        return v;
    endfunction

    // Bits that wait for vertical sync before becoming visible.
    function automatic logic [BYTE_W-1:0] stage_mask(input int idx);
        logic [BYTE_W-1:0] m;
        case (idx)
            4, 5, 7, 10, 23: m = 8'hFF;
            6:               m = 8'h18;
            default:         m = 8'h00;
        endcase
        return m;
    endfunction

    // Indices that accept no writes.
    function automatic logic is_blocked(input int idx);
        logic b;
        case (idx)
            0, 1, 11, 12, 17, 27, 28: b = 1'b1;
            default:                  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/vcr_line_sync.sv
module vcr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/vcr_bus_fsm.sv
module vcr_bus_fsm
    import vcr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1011101,
    parameter int         AW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    status_byte,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(8);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(7);

    slv_state_e       st, nxt;
    logic [7:0]       sh;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    ptr;
    logic             mack;
    logic             byte_done;

    assign byte_done = scl_fall && (cnt == FULL);

    // next-state decision
    always_comb begin
        nxt = st;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = (sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)  nxt = sh[0] ? ST_TX : ST_SUB;
                ST_SUB:      if (byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  nxt = ST_DATA;
                ST_TX:       if (scl_fall && cnt == LAST) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall)  nxt = mack ? ST_TX : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            ptr     <= '0;
            mack    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_SUB, ST_DATA: begin
                        if (scl_rise && cnt < FULL) begin
                            sh  <= {sh[6:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end
                        if (byte_done) begin
                            cnt <= '0;
                            if (st == ST_SUB) ptr <= sh;
                            if (st == ST_DATA) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (sh[0]) sh <= status_byte;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            cnt <= cnt + 1'b1;
                            sh  <= {sh[6:0], 1'b0};
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            cnt <= '0;
                            sh  <= status_byte;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line drive
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_TX:                                sda_pull = ~sh[7];
            default:                              sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/vcr_reg_file.sv
module vcr_reg_file
    import vcr_pkg::*;
#(
    parameter int N_REG = 29,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               vsync_stb,
    output logic [N_REG*8-1:0] regs_flat
);

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        localparam logic [7:0]    RV   = reset_value(i);
        localparam logic [7:0]    MASK = stage_mask(i);
        localparam logic [AW-1:0] IDX  = AW'(i);

        if (is_blocked(i)) begin : g_blocked
            assign regs_flat[i*8 +: 8] = '0;
        end else if (MASK == 8'h00) begin : g_direct
            logic [7:0] act_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      act_q <= RV;
                else if (wr_en && wr_addr == IDX) act_q <= wr_data;
            end
            assign regs_flat[i*8 +: 8] = act_q;
        end else begin : g_staged
            logic [7:0] act_q, shd_q, act_d;
            logic       hit;
            assign hit = wr_en && (wr_addr == IDX);
            always_comb begin
                act_d = act_q;
                if (vsync_stb) act_d = (act_d & ~MASK) | (shd_q & MASK);
                if (hit)       act_d = (act_d & MASK) | (wr_data & ~MASK);
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_q <= RV;
                    shd_q <= RV;
                end else begin
                    act_q <= act_d;
                    if (hit) shd_q <= wr_data;
                end
            end
            assign regs_flat[i*8 +: 8] = act_q;
        end
    end

endmodule

// File: rtl/vid_ctrl_regbank.sv
module vid_ctrl_regbank #(
    parameter int         N_REG       = 29,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1011101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               vsync_stb,
    input  logic [5:0]         stat_in,
    output logic               sda_pull,
    output logic [N_REG*8-1:0] regs_out
);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    status_byte;

    assign status_byte = {stat_in[5], 1'b0, stat_in[4:0], 1'b0};

    vcr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    vcr_bus_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .status_byte (status_byte),
        .sda_pull    (sda_pull),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

    vcr_reg_file #(.N_REG(N_REG), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .vsync_stb (vsync_stb),
        .regs_flat (regs_out)
    );

endmodule

// File: rtl/vcr_regbank_chk.sv
module vcr_regbank_chk #(
    parameter int N_REG = 29
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               sda_pull,
    input logic               vsync_stb,
    input logic               wr_en,
    input logic [N_REG*8-1:0] regs_flat
);

    // R2: data line drive is steady while the clock line is high
    assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));

    // R3: a committed write coincides with the acknowledge drive
    assert_ack_with_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull);

    // R3: an unstaged register (index 8) moves only after a commit
    assert_direct_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(regs_flat[8*8 +: 8]));

    // R5: a staged register (index 5) moves only after the sync strobe
    assert_staged_on_vsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vsync_stb) |-> $stable(regs_flat[5*8 +: 8]));

endmodule

bind vid_ctrl_regbank vcr_regbank_chk #(.N_REG(N_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_pull  (sda_pull),
    .vsync_stb (vsync_stb),
    .wr_en     (wr_en),
    .regs_flat (regs_out)
);

// File: tb/vid_ctrl_regbank_test.sv
module vid_ctrl_regbank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 29;
    localparam int Q  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_low = 1'b0;
    logic          vsync_stb = 1'b0;
    logic [5:0]    stat_in = 6'd0;
    logic          sda_pull;
    logic [NR*8-1:0] regs_out;
    wire           sda_line = !(m_low || sda_pull);

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;
    int exp_act [NR];
    int exp_shd [NR];

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_ctrl_regbank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .vsync_stb (vsync_stb),
        .stat_in   (stat_in),
        .sda_pull  (sda_pull),
        .regs_out  (regs_out)
    );

    // ---- reference model data, taken from R1, R5, R7, R8 ----
    function automatic int m_reset(input int i);
        if (i == 4) return 'h20;
        if (i == 5 || i == 7 || i == 8 || i == 23) return 'h40;
        if (i == 6 || i == 10 || (i >= 13 && i <= 15)) return 'h80;
        if (i == 16) return 'h24;
        if (i == 22) return 'h90;
        return 0;
    endfunction

    function automatic int m_mask(input int i);
        if (i == 4 || i == 5 || i == 7 || i == 10 || i == 23) return 'hFF;
        if (i == 6) return 'h18;
        return 0;
    endfunction

    function automatic bit m_blocked(input int i);
        return (i == 0 || i == 1 || i == 11 || i == 12 || i == 17 || i >= 27);
    endfunction

    function automatic int m_status(input logic [5:0] s);
        return (s[5] << 7) | (s[4] << 5) | (s[3] << 4) | (s[2] << 3) | (s[1] << 2) | (s[0] << 1);
    endfunction

    task automatic model_write(input int sub, input int d);
        if (sub < NR && !m_blocked(sub)) begin
            exp_shd[sub] = d;
            exp_act[sub] = (exp_act[sub] & m_mask(sub)) | (d & ~m_mask(sub) & 'hFF);
        end
    endtask

    task automatic model_vsync();
        for (int i = 0; i < NR; i++)
            exp_act[i] = (exp_act[i] & ~m_mask(i) & 'hFF) | (exp_shd[i] & m_mask(i));
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // every-clock comparison against the model (R1, R3..R8)
    always @(negedge clk) begin
        if (cmp_en && rst_n && !done) begin
            checks++;
            for (int i = 0; i < NR; i++) begin
                if (int'(regs_out[i*8 +: 8]) != exp_act[i]) begin
                    fails++;
                    $display("FAIL model R3 reg 0x%0h actual=0x%0h expected=0x%0h",
                             i, regs_out[i*8 +: 8], exp_act[i]);
                    break;
                end
            end
        end
    end

    function automatic int rd(input int i);
        return int'(regs_out[i*8 +: 8]);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---- bus master ----
    task automatic bus_start();
        m_low = 1'b0; m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = !sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_scl = 1'b1; tick(Q);
            d[i] = sda_line; tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_low = give_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    task automatic wr_regs(input int sub, input int n, input int d0, input int d1, input int d2);
        bit ack;
        int dv;
        bus_start();
        send_byte(8'hBA, ack);
        check("R2 write address ack", ack, 1);
        send_byte(sub[7:0], ack);
        check("R2 index ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            dv = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            cmp_en = 1'b0;
            send_byte(dv[7:0], ack);
            check("R8 data ack", ack, 1);
            model_write((sub + k) & 'hFF, dv);
            cmp_en = 1'b1;
        end
        bus_stop();
    endtask

    task automatic pulse_vsync();
        cmp_en = 1'b0;
        vsync_stb = 1'b1; tick(1);
        vsync_stb = 1'b0;
        model_vsync();
        tick(1);
        cmp_en = 1'b1;
        tick(2);
    endtask

    task automatic read_status(input int nbytes, input int exp);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hBB, ack);
        check("R2 read address ack", ack, 1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k != nbytes - 1, d);
            check("R9 status byte", int'(d), exp);
        end
        bus_stop();
    endtask

    // ---- watchdog ----
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---- stimulus ----
    initial begin
        bit ack;
        for (int i = 0; i < NR; i++) begin
            exp_act[i] = m_reset(i);
            exp_shd[i] = m_reset(i);
        end
        tick(5);
        rst_n = 1'b1;
        tick(3);
        cmp_en = 1'b1;

        // R1 reset contents
        check("R1 contrast reset", rd(5), 'h40);
        check("R1 brightness reset", rd(10), 'h80);
        check("R1 cut-off reset", rd(14), 'h80);
        check("R1 line osc reset", rd(16), 'h24);
        check("R1 idle line drive", int'(sda_pull), 0);

        // R2 foreign address not acknowledged
        bus_start();
        send_byte(8'hB8, ack);
        check("R2 foreign address nack", ack, 0);
        bus_stop();

        // R3 direct register
        wr_regs('h08, 1, 'h55, 0, 0);
        check("R3 direct write", rd(8), 'h55);

        // R4 auto increment across three bytes
        wr_regs('h0D, 3, 'h11, 'h22, 'h33);
        check("R4 first byte", rd(13), 'h11);
        check("R4 second byte", rd(14), 'h22);
        check("R4 third byte", rd(15), 'h33);

        // R5 staged register held until strobe
        wr_regs('h05, 1, 'h11, 0, 0);
        tick(20);
        check("R5 held before vsync", rd(5), 'h40);
        pulse_vsync();
        check("R5 applied on vsync", rd(5), 'h11);

        // R6 last pending value wins
        wr_regs('h05, 1, 'h22, 0, 0);
        wr_regs('h05, 1, 'h33, 0, 0);
        check("R6 still old value", rd(5), 'h11);
        pulse_vsync();
        check("R6 last value taken", rd(5), 'h33);

        // R7 mixed register
        wr_regs('h06, 1, 'h1B, 0, 0);
        check("R7 immediate bits only", rd(6), 'h03);
        pulse_vsync();
        check("R7 staged bits after vsync", rd(6), 'h1B);

        // R8 blocked and out-of-range indices
        wr_regs('h0B, 1, 'hFF, 0, 0);
        check("R8 blocked index stays zero", rd(11), 0);
        wr_regs('h1C, 2, 'h77, 'h66, 0);
        check("R8 last index stays zero", rd(28), 0);
        check("R8 neighbour untouched", rd(26), 0);

        // R9 status read
        stat_in = 6'b101010;
        read_status(1, m_status(6'b101010));
        stat_in = 6'b010101;
        read_status(1, m_status(6'b010101));
        stat_in = 6'b111111;
        read_status(2, m_status(6'b111111));

        // R10 STOP mid-byte abandons the byte
        bus_start();
        send_byte(8'hBA, ack);
        send_byte(8'h08, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        tick(10);
        check("R10 partial byte discarded", rd(8), 'h55);
        wr_regs('h08, 1, 'h66, 0, 0);
        check("R10 next transaction works", rd(8), 'h66);

        tick(20);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule